// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a built-in self-test over a window of addresses on a DRAM-style request port. Software first sets the lower and upper addresses of the window and the pseudo-random seed. It then writes a 32-bit control/status word that has the start bit set. The engine writes pseudo-random data to every address in the window, in ascending order. It then reads the same addresses back in the same order and compares each returned word with a regenerated copy of the data it wrote.

Requests leave the block at a rate of one per cycle, with no backpressure. Read data comes back in request order with a valid strobe, after any latency. The control/status word shows progress and result. The engine clears the start bit when the test ends. It sets a sticky fail flag on any miscompare. It honours a halt-on-first-error bit and an abort request. A small logger counts miscompares and holds the address of the first one.

Top module: `mbist_engine`

## Requirements
- R1: After reset the control/status word reads 0, no request is issued, `done` is 0, the seed register holds 0xACE12345 and the window registers hold 0.
- R2: Writing the control word (reg_sel 0) while idle stores all 32 bits. If bit 31 is 1, bits [5:4] = 11, bits [9:8] = 11, bits [7:6] = 10, bits [26:24] = 0 and bit 28 = 0, a write pass starts. It issues one write request per cycle from the cycle after the write, at addresses lower..upper ascending (reg_sel 1 = lower, 2 = upper, both inclusive). `req_rank` carries bits [21:20].
- R3: The write data starts at the seed (reg_sel 3) and then moves to the next value each write. The next value is {s[30:0], ^(s & 0x80200003)}.
- R4: The cycle after the last write, the read pass issues reads over the same addresses in the same order, one per cycle. `req_cmd` is 0 for write and 1 for read.
- R5: Each read response, taken in order, is compared with the regenerated data sequence of R3. A miscompare sets bit 30, which stays set until software writes it. A miscompare also adds one to `fail_count` and records the address in `first_fail_addr` if it is the first.
- R6: At the clock edge that samples the last response, bit 31 clears and `done` rises for exactly one cycle.
- R7: With bit 29 set, the first miscompare ends the run in the way R6 describes. Responses still in flight are ignored, so `fail_count` stays 1.
- R8: A control write with bit 28 set during a run ends it at that edge. No further request follows, bit 31 clears, bit 28 reads 1, bit 30 keeps its value and `done` pulses.
- R9: A start whose command, data-type, address-type, algorithm or abort field differs from R2 stores the word with bit 31 cleared and issues no request.
- R10: Bit 19 (invert) and bit 15 (wide data) have no effect on the write data.
- R11: A control write while idle replaces the whole word, so software can clear bit 30. A new run resets `fail_count` to 0.
- R12: A window whose lower address equals its upper address gives exactly one write and one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control word, 1 lower address, 2 upper address, 3 seed |
| reg_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Current control/status word |
| req_valid | output | 1 | Request issued this cycle |
| req_cmd | output | 1 | 0 write, 1 read |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Write data |
| req_rank | output | 2 | Rank select from control bits [21:20] |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | DW | Read data |
| done | output | 1 | One-cycle pulse when a run ends |
| fail | output | 1 | Copy of the sticky fail flag |
| fail_count | output | CW | Saturating miscompare count |
| first_fail_addr | output | AW | Address of the first miscompare |

## Verification
A driver pushes each run's expected writes and reads into a queue. A monitor samples at the falling edge and pops one entry for every cycle in which `req_valid` is high, so the first request is due one cycle after the control write and requests must arrive back to back. A memory model in the monitor answers each read three cycles later. The bench then checks that `done` is high for exactly one falling-edge sample, the one after the rising edge that took the final (or halting) response. Abort and invalid-start effects are sampled at the first falling edge after the write that caused them.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int unsigned START_BIT = 31;
  localparam int unsigned FAIL_BIT  = 30;
  localparam int unsigned HALT_BIT  = 29;
  localparam int unsigned ABORT_BIT = 28;
  localparam int unsigned SEL_CSR   = 0;
  localparam int unsigned SEL_LO    = 1;
  localparam int unsigned SEL_HI    = 2;
  localparam int unsigned SEL_SEED  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } mb_state_e;

  // Only write-then-compare, random data and windowed addressing are runnable.
  function automatic logic mb_cfg_ok(input logic [31:0] w);
    return (w[5:4] == 2'b11) && (w[9:8] == 2'b11) && (w[7:6] == 2'b10) &&
           (w[26:24] == 3'd0) && !w[ABORT_BIT];
  endfunction
endpackage

// File: rtl/mbist_rst_sync.sv
module mbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mbist_lfsr.sv
module mbist_lfsr #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load)      state_d = seed;
    else if (step) state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign value = state_q;
endmodule

// File: rtl/mbist_addrgen.sv
module mbist_addrgen #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = base;
    else if (step) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
  assign last = (addr_q == limit);
endmodule

// File: rtl/mbist_faillog.sv
module mbist_faillog #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          hit,
  input  logic [AW-1:0] hit_addr,
  output logic [CW-1:0] count,
  output logic [AW-1:0] first_addr
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] first_q, first_d;
  logic          first_en;

  always_comb begin
    cnt_d    = cnt_q;
    first_en = 1'b0;
    first_d  = hit_addr;
    if (clear) begin
      cnt_d    = '0;
      first_en = 1'b1;
      first_d  = '0;
    end else if (hit) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CW'(1);
      first_en = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        first_q <= '0;
    else if (first_en) first_q <= first_d;
  end

  assign count      = cnt_q;
  assign first_addr = first_q;
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   CW       = 8,
  parameter logic [DW-1:0] TAPS     = 32'h8020_0003,
  parameter logic [DW-1:0] SEED_RST = 32'hACE1_2345
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   csr_rdata,
  output logic          req_valid,
  output logic          req_cmd,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [1:0]    req_rank,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          done,
  output logic          fail,
  output logic [CW-1:0] fail_count,
  output logic [AW-1:0] first_fail_addr
);
  logic          rst_ns;
  mb_state_e     st_q, st_d;
  logic [31:0]   csr_q, csr_d;
  logic          done_q, done_d;
  logic [AW-1:0] lo_addr_q, hi_addr_q;
  logic [DW-1:0] seed_q;

  logic          csr_wr, idle_wr;
  logic          lfsr_load, lfsr_step;
  logic [DW-1:0] lfsr_val;
  logic          iss_load, iss_step, iss_last;
  logic [AW-1:0] iss_addr;
  logic          chk_load, chk_step, chk_last;
  logic [AW-1:0] chk_addr;
  logic          log_clear, log_hit;
  logic          mismatch, finish, comparing;

  mbist_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  mbist_lfsr #(.W(DW), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_ns), .load(lfsr_load), .seed(seed_q),
    .step(lfsr_step), .value(lfsr_val)
  );

  mbist_addrgen #(.AW(AW)) u_iss (
    .clk(clk), .rst_n(rst_ns), .load(iss_load), .base(lo_addr_q),
    .limit(hi_addr_q), .step(iss_step), .addr(iss_addr), .last(iss_last)
  );

  mbist_addrgen #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_ns), .load(chk_load), .base(lo_addr_q),
    .limit(hi_addr_q), .step(chk_step), .addr(chk_addr), .last(chk_last)
  );

  mbist_faillog #(.AW(AW), .CW(CW)) u_log (
    .clk(clk), .rst_n(rst_ns), .clear(log_clear), .hit(log_hit),
    .hit_addr(chk_addr), .count(fail_count), .first_addr(first_fail_addr)
  );

  assign csr_wr    = reg_wr && (reg_sel == 2'(SEL_CSR));
  assign idle_wr   = reg_wr && (st_q == ST_IDLE);
  assign comparing = ((st_q == ST_READ) || (st_q == ST_DRAIN)) && rsp_valid;
  assign mismatch  = (rsp_rdata != lfsr_val);

  // Window and seed registers: writable only while idle.
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                                   lo_addr_q <= '0;
    else if (idle_wr && reg_sel == 2'(SEL_LO))     lo_addr_q <= reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                                   hi_addr_q <= '0;
    else if (idle_wr && reg_sel == 2'(SEL_HI))     hi_addr_q <= reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                                   seed_q <= SEED_RST;
    else if (idle_wr && reg_sel == 2'(SEL_SEED))   seed_q <= reg_wdata[DW-1:0];
  end

  // Next-state logic.
  always_comb begin
    st_d      = st_q;
    csr_d     = csr_q;
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    iss_load  = 1'b0;
    iss_step  = 1'b0;
    chk_load  = 1'b0;
    chk_step  = 1'b0;
    log_clear = 1'b0;
    log_hit   = 1'b0;
    finish    = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (csr_wr) begin
          csr_d = reg_wdata;
          if (reg_wdata[START_BIT]) begin
            if (mb_cfg_ok(reg_wdata)) begin
              st_d      = ST_WRITE;
              lfsr_load = 1'b1;
              iss_load  = 1'b1;
              log_clear = 1'b1;
            end else begin
              csr_d[START_BIT] = 1'b0;
            end
          end
        end
      end
      ST_WRITE: begin
        iss_step  = 1'b1;
        lfsr_step = 1'b1;
        if (iss_last) begin
          st_d      = ST_READ;
          lfsr_load = 1'b1;
          iss_load  = 1'b1;
          chk_load  = 1'b1;
        end
      end
      ST_READ: begin
        iss_step = 1'b1;
        if (iss_last) st_d = ST_DRAIN;
      end
      default: ;
    endcase

    if (comparing) begin
      lfsr_step = 1'b1;
      chk_step  = 1'b1;
      if (mismatch) begin
        csr_d[FAIL_BIT] = 1'b1;
        log_hit         = 1'b1;
      end
      if (chk_last || (mismatch && csr_q[HALT_BIT])) finish = 1'b1;
    end

    if ((st_q != ST_IDLE) && csr_wr && reg_wdata[ABORT_BIT]) begin
      finish           = 1'b1;
      log_hit          = 1'b0;
      csr_d[ABORT_BIT] = 1'b1;
      csr_d[FAIL_BIT]  = csr_q[FAIL_BIT];
    end

    done_d = finish;
    if (finish) begin
      st_d             = ST_IDLE;
      csr_d[START_BIT] = 1'b0;
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      csr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      csr_q  <= csr_d;
      done_q <= done_d;
    end
  end

  assign req_valid = (st_q == ST_WRITE) || (st_q == ST_READ);
  assign req_cmd   = (st_q == ST_READ);
  assign req_addr  = iss_addr;
  assign req_wdata = (st_q == ST_WRITE) ? lfsr_val : '0;
  assign req_rank  = csr_q[21:20];
  assign csr_rdata = csr_q;
  assign done      = done_q;
  assign fail      = csr_q[FAIL_BIT];
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   csr_rdata,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          done,
  input logic [AW-1:0] lo_addr,
  input logic [AW-1:0] hi_addr
);
  // R2: requests only while the start bit is set
  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> csr_rdata[31]);

  // R2: request addresses stay inside the window
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr >= lo_addr) && (req_addr <= hi_addr));

  // R5: fail flag stays set for the rest of a run
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31] && csr_rdata[30]) |=> csr_rdata[30]);

  // R6: done is a single-cycle pulse with start already cleared
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !csr_rdata[31]);

  // R8: abort stops requests at the next edge
  a_r8_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31] && reg_wr && reg_sel == 2'd0 && reg_wdata[28])
      |=> (!req_valid && !csr_rdata[31] && done));
endmodule

bind mbist_engine mbist_engine_chk #(.AW(AW)) u_chk_bind (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
  .req_addr(req_addr), .done(done), .lo_addr(lo_addr_q), .hi_addr(hi_addr_q)
);

// File: tb/test_mbist_engine.sv
module test_mbist_engine;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam logic [31:0] POLY = 32'h8020_0003;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   csr_rdata;
  logic          req_valid, req_cmd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_rank;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;
  logic          done, fail;
  logic [CW-1:0] fail_count;
  logic [AW-1:0] first_fail_addr;

  always #10 clk = ~clk;

  mbist_engine i_mbist_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rank(req_rank), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done(done), .fail(fail), .fail_count(fail_count),
    .first_fail_addr(first_fail_addr)
  );

  typedef struct packed {
    logic          cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    rank;
  } item_t;

  item_t         exp_q[$];
  logic [DW-1:0] mem [int];
  int            n_chk = 0, n_fail = 0, req_seen = 0;
  logic          bad_en = 1'b0;
  logic [AW-1:0] bad0 = '0, bad1 = '0;
  logic          pv[3];
  logic [DW-1:0] pd[3];

  task automatic chk(input bit ok, input string r, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], ^(s & POLY)};
  endfunction

  // Monitor: pops expected requests, models memory with 3-cycle read latency.
  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    forever begin
      @(negedge clk);
      rsp_valid = pv[0];
      rsp_rdata = pd[0];
      pv[0] = pv[1]; pd[0] = pd[1];
      pv[1] = pv[2]; pd[1] = pd[2];
      pv[2] = 1'b0;  pd[2] = '0;
      if (req_valid) begin
        item_t got, ex;
        req_seen++;
        got = '{req_cmd, req_addr, req_wdata, req_rank};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected request", 64'(got), 64'(0));
        end else begin
          ex = exp_q.pop_front();
          chk(got == ex, ex.cmd ? "R4 read request" : "R2/R3 write request",
              64'(got), 64'(ex));
        end
        if (!req_cmd) begin
          mem[int'(req_addr)] = req_wdata;
        end else begin
          pv[2] = 1'b1;
          pd[2] = mem.exists(int'(req_addr)) ? mem[int'(req_addr)] : '0;
          if (bad_en && (req_addr == bad0 || req_addr == bad1)) pd[2][0] = ~pd[2][0];
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk_csr(input bit halt, input bit failb,
      input logic [1:0] rank, input bit inv, input bit wide);
    logic [31:0] w = '0;
    w[31] = 1'b1; w[30] = failb; w[29] = halt;
    w[21:20] = rank; w[19] = inv; w[15] = wide;
    w[9:8] = 2'b11; w[7:6] = 2'b10; w[5:4] = 2'b11;
    return w;
  endfunction

  // Driver: programs window, pushes expected items, starts the run.
  task automatic start_run(input int lo, input int hi, input logic [31:0] seed,
                           input logic [31:0] word);
    logic [31:0] s;
    wr_reg(2'd1, 32'(lo));
    wr_reg(2'd2, 32'(hi));
    wr_reg(2'd3, seed);
    s = seed;
    for (int a = lo; a <= hi; a++) begin
      exp_q.push_back('{1'b0, AW'(a), s, word[21:20]});
      s = nxt(s);
    end
    for (int a = lo; a <= hi; a++) exp_q.push_back('{1'b1, AW'(a), '0, word[21:20]});
    wr_reg(2'd0, word);
  endtask

  task automatic wait_done(input string r);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, r, 64'(done), 64'(1));
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int seen;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(csr_rdata == 0 && !req_valid && !done, "R1 reset state",
        {csr_rdata, 31'b0, req_valid}, 0);

    // R2 R3 R4 R6: default seed, clean memory
    w = mk_csr(1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
    start_run(16, 23, 32'hACE1_2345, w);
    wait_done("R6 done after last response");
    chk(!csr_rdata[31] && !fail && fail_count == 0, "R6 clean run result",
        {csr_rdata, 24'b0, fail_count}, {w & 32'h7fff_ffff, 32'b0});
    chk(exp_q.size() == 0, "R4 all requests issued", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
    settle();

    // R5 R10: new seed, invert/wide set, two corrupted reads, no halt
    bad_en = 1'b1; bad0 = 16'h0042; bad1 = 16'h0047;
    w = mk_csr(1'b0, 1'b0, 2'b10, 1'b1, 1'b1);
    start_run(64, 75, 32'h1357_9BDF, w);
    wait_done("R5 run completes");
    chk(fail && csr_rdata[30], "R5 fail flag set", csr_rdata[30], 1);
    chk(fail_count == 2, "R5 miscompare count", fail_count, 2);
    chk(first_fail_addr == 16'h0042, "R5 first fail address", first_fail_addr, 16'h42);
    chk(exp_q.size() == 0, "R10 write data unaffected", exp_q.size(), 0);
    settle();
    chk(fail, "R5 fail flag sticky when idle", fail, 1);

    // R11: software clears fail flag
    wr_reg(2'd0, 32'h0000_0A00);
    @(negedge clk);
    chk(csr_rdata == 32'h0000_0A00, "R11 whole word replaced", csr_rdata, 32'h0A00);

    // R7: halt at first error
    bad0 = 16'h0023; bad1 = 16'h0028;
    w = mk_csr(1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    start_run(32, 47, 32'h0BAD_F00D, w);
    wait_done("R7 halt ends run");
    chk(fail_count == 1, "R7 halt count", fail_count, 1);
    chk(first_fail_addr == 16'h0023 && fail, "R7 halt address", first_fail_addr, 16'h23);
    settle();
    chk(fail_count == 1, "R7 late responses ignored", fail_count, 1);
    bad_en = 1'b0;

    // R8: abort during write pass; fail flag written as 1 stays 1
    w = mk_csr(1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
    start_run(0, 63, 32'h2468_ACE0, w);
    chk(fail_count == 0, "R11 count cleared at start", fail_count, 0);
    repeat (10) @(negedge clk);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1000_0000;
    @(posedge clk); #2;
    reg_wr = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(!req_valid && !csr_rdata[31] && csr_rdata[28] && csr_rdata[30] && done,
        "R8 abort stop", {req_valid, csr_rdata}, {1'b0, 32'h5000_0000 | (w & 32'h3fff_ffff)});
    settle();

    // R9: invalid command field
    seen = req_seen;
    w = mk_csr(1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    w[5:4] = 2'b01;
    wr_reg(2'd0, w);
    @(negedge clk);
    chk(csr_rdata == (w & 32'h7fff_ffff), "R9 start refused", csr_rdata, w & 32'h7fff_ffff);
    repeat (10) @(negedge clk);
    chk(req_seen == seen, "R9 no requests", req_seen, seen);

    // R9: nonzero algorithm field
    w = mk_csr(1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    w[26:24] = 3'd2;
    wr_reg(2'd0, w);
    repeat (6) @(negedge clk);
    chk(!csr_rdata[31] && req_seen == seen, "R9 algorithm field refused",
        {csr_rdata[31], 32'(req_seen)}, {1'b0, 32'(seen)});

    // R12: single-address window
    seen = req_seen;
    w = mk_csr(1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
    start_run(200, 200, 32'h0000_0001, w);
    wait_done("R12 single address done");
    chk(req_seen - seen == 2 && !fail, "R12 one write one read", req_seen - seen, 2);
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule